// File: doc/BRIEF.md
# Main Oscillator Failure Supervisor

This block watches the clock of an external high-speed oscillator from a free-running reference clock and takes over recovery when that clock stops. Supervision is armed only when software has enabled it, the oscillator enable is on, and the oscillator reports that its startup delay is over. Inside the monitored clock domain, a divider bit toggles at a fixed rate. The reference domain synchronizes that toggle through a flop chain and counts reference cycles between observed toggles. When the count reaches a programmable limit, the block declares a failure.

On a failure the block acts without waiting for software. It clears the oscillator enable and sends a one-cycle break pulse to the timers. It latches a pending flag, which drives a non-maskable interrupt request until software writes the clear strobe. If the system clock depends on the failed oscillator, either directly or through a PLL that the oscillator feeds, the system clock select moves to one of two internal backup sources. In the PLL case the PLL enable is also cleared. The clock tree itself is outside the block and is represented by the select code and the two enable outputs.

Top module: `osc_fail_guard`

## Requirements
- R1: After reset, osc_en, pll_en, brk_pulse and nmi_req are 0, and sys_sel is 0.
- R2: No failure is declared while sup_en is 0 or osc_ready is 0, even if the monitored clock is stopped. Once both are 1 with osc_en on and the monitored clock stopped, brk_pulse rises exactly miss_limit reference cycles after arming.
- R3: While the monitored clock runs, no failure is declared. After it stops, brk_pulse is high for exactly one reference cycle, about miss_limit cycles later. Each failure produces one pulse only.
- R4: A failure clears osc_en without any software command.
- R5: A failure sets nmi_req. nmi_req stays 1 until clr_pend is strobed, and is 0 in the cycle after the strobe.
- R6: The sys_sel codes are 0 = internal source A, 1 = internal source B, 2 = oscillator direct, 3 = PLL. If sys_sel is 2 at a failure, it becomes backup_b (0 selects A, 1 selects B).
- R7: If sys_sel is 3 and pll_from_osc is 1 at a failure, sys_sel becomes backup_b and pll_en is cleared.
- R8: If the oscillator is not in the system clock path (sys_sel 0 or 1, or sys_sel 3 with pll_from_osc 0), a failure leaves both sys_sel and pll_en unchanged.
- R9: Strobing clr_pend while nmi_req is 0 changes no output.
- R10: After a failure, the detector stays idle until osc_en is turned on again and osc_ready is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_clk | input | 1 | Monitored oscillator clock |
| sup_en | input | 1 | Software enable for supervision |
| osc_ready | input | 1 | Oscillator startup delay finished |
| osc_on | input | 1 | Strobe: turn the oscillator enable on |
| osc_off | input | 1 | Strobe: turn the oscillator enable off |
| pll_on | input | 1 | Strobe: turn the PLL enable on |
| pll_off | input | 1 | Strobe: turn the PLL enable off |
| pll_from_osc | input | 1 | PLL reference is the oscillator |
| sel_wr | input | 1 | Strobe: load sel_wdata into sys_sel |
| sel_wdata | input | 2 | New system clock select code |
| backup_b | input | 1 | Backup choice: 0 = source A, 1 = source B |
| clr_pend | input | 1 | Strobe: clear the failure pending flag |
| miss_limit | input | LIM_W | Reference cycles without an edge before a failure is declared |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| sys_sel | output | 2 | System clock select code |
| brk_pulse | output | 1 | One-cycle failure event for timer break inputs |
| nmi_req | output | 1 | Non-maskable interrupt request |

## Verification
All actions taken on a failure appear together, one register stage after the cycle in which the counter hits the limit. These are the brk_pulse edge, the cleared enables, the new select code and nmi_req. A clear strobe takes effect one cycle later. When the monitored clock is already stopped and the detector is then armed, brk_pulse is due exactly miss_limit cycles after arming, and the bench checks that count exactly. When the clock is stopped mid-run, the time of its last synchronized toggle is not fixed, so the bench accepts a small window around miss_limit. The bench drives and samples on the falling edge of the reference clock and counts cycles there. It reads the other failure outputs in the same sample that first shows brk_pulse.

// File: rtl/osc_fail_guard.sv
module osc_fail_guard #(
  parameter int LIM_W   = 8,
  parameter int MON_DIV = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mon_clk,
  input  logic             sup_en,
  input  logic             osc_ready,
  input  logic             osc_on,
  input  logic             osc_off,
  input  logic             pll_on,
  input  logic             pll_off,
  input  logic             pll_from_osc,
  input  logic             sel_wr,
  input  logic [1:0]       sel_wdata,
  input  logic             backup_b,
  input  logic             clr_pend,
  input  logic [LIM_W-1:0] miss_limit,
  output logic             osc_en,
  output logic             pll_en,
  output logic [1:0]       sys_sel,
  output logic             brk_pulse,
  output logic             nmi_req
);

  localparam logic [1:0] SEL_DIRECT = 2'd2;
  localparam logic [1:0] SEL_PLL    = 2'd3;

  logic [MON_DIV:0] mdiv;
  always_ff @(posedge mon_clk or negedge rst_n)
    if (!rst_n) mdiv <= '0;
    else        mdiv <= mdiv + {{MON_DIV{1'b0}}, 1'b1};

  logic [2:0] sy;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sy <= '0;
    else        sy <= {sy[1:0], mdiv[MON_DIV]};

  wire edge_seen = sy[2] ^ sy[1];
  wire armed     = sup_en & osc_en & osc_ready;

  logic [LIM_W-1:0] cnt;
  wire  [LIM_W:0]   cnt_nx = {1'b0, cnt} + {{LIM_W{1'b0}}, 1'b1};
  wire  fail     = armed & ~edge_seen & (cnt_nx == {1'b0, miss_limit});
  wire  path_dir = (sys_sel == SEL_DIRECT);
  wire  path_pll = (sys_sel == SEL_PLL) & pll_from_osc;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  cnt <= '0;
    else if (!armed || edge_seen) cnt <= '0;
    else                         cnt <= cnt_nx[LIM_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_en    <= 1'b0;
      pll_en    <= 1'b0;
      sys_sel   <= 2'd0;
      brk_pulse <= 1'b0;
      nmi_req   <= 1'b0;
    end else begin
      brk_pulse <= fail;

      if (fail)         osc_en <= 1'b0;
      else if (osc_off) osc_en <= 1'b0;
      else if (osc_on)  osc_en <= 1'b1;

      if (fail && path_pll) pll_en <= 1'b0;
      else if (pll_off)     pll_en <= 1'b0;
      else if (pll_on)      pll_en <= 1'b1;

      if (fail && (path_dir || path_pll)) sys_sel <= {1'b0, backup_b};
      else if (sel_wr)                    sys_sel <= sel_wdata;

      if (fail)          nmi_req <= 1'b1;
      else if (clr_pend) nmi_req <= 1'b0;
    end
  end

  a_r4_osc_killed: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |-> !osc_en);
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |=> !brk_pulse);
  a_r2_only_when_armed: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |-> $past(armed));
  a_r5_nmi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req && !clr_pend) |=> nmi_req);
  a_r5_nmi_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |-> nmi_req);
  a_r6_left_direct: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |-> (sys_sel != SEL_DIRECT));
  a_r7_pll_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_pulse && $past(pll_from_osc)) |-> !(sys_sel == SEL_PLL && pll_en));
  a_r9_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!nmi_req && clr_pend && !armed) |=> !nmi_req);

endmodule

// File: tb/tb_osc_fail_guard.sv
module tb_osc_fail_guard;
  logic clk = 1'b0, mon_clk = 1'b0, mon_run = 1'b1, rst_n = 1'b0;
  logic sup_en = 0, osc_ready = 0, osc_on = 0, osc_off = 0, pll_on = 0, pll_off = 0;
  logic pll_from_osc = 0, sel_wr = 0, backup_b = 0, clr_pend = 0;
  logic [1:0] sel_wdata = 0;
  logic [7:0] miss_limit = 8'd10;
  logic osc_en, pll_en, brk_pulse, nmi_req;
  logic [1:0] sys_sel;
  int n_chk = 0, n_fail = 0, brk_cnt = 0;

  always #4 clk = ~clk;
  always #5 if (mon_run) mon_clk = ~mon_clk;
  always @(posedge clk) if (brk_pulse) brk_cnt++;

  osc_fail_guard dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe_clear();
    osc_on = 0; osc_off = 0; pll_on = 0; pll_off = 0; sel_wr = 0; clr_pend = 0;
  endtask

  task automatic wait_brk(output int n);
    n = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk); n++;
      if (brk_pulse) break;
    end
  endtask

  task automatic run_case(input int lim, input int mode, input bit bk);
    int n, b0, es, ep;
    logic [1:0] s;
    bit pfo;
    case (mode)
      0: begin s = 2'd2; pfo = 1; end
      1: begin s = 2'd3; pfo = 1; end
      2: begin s = 2'd3; pfo = 0; end
      default: begin s = 2'd1; pfo = 1; end
    endcase
    es = (mode <= 1) ? int'(bk) : int'(s);
    ep = (mode == 1) ? 0 : 1;
    @(negedge clk);
    mon_run = 1; osc_ready = 0; sup_en = 1; miss_limit = 8'(lim); backup_b = bk;
    pll_from_osc = pfo; sel_wr = 1; sel_wdata = s; pll_on = 1; osc_on = 1; clr_pend = 1;
    @(negedge clk); strobe_clear();
    repeat (3) @(negedge clk);
    osc_ready = 1;
    b0 = brk_cnt;
    repeat (120) @(negedge clk);
    chk(brk_cnt == b0, "R3 no failure while clock runs", brk_cnt - b0, 0);
    mon_run = 0;
    wait_brk(n);
    chk(brk_pulse && n >= lim - 3 && n <= lim + 5, "R3 failure delay", n, lim);
    chk(osc_en == 0, "R4 oscillator disabled", osc_en, 0);
    chk(nmi_req == 1, "R5 nmi raised", nmi_req, 1);
    chk(sys_sel == 2'(es), (mode == 0) ? "R6 backup select" : (mode == 1) ? "R7 backup select" : "R8 select kept",
        sys_sel, es);
    chk(pll_en == 1'(ep), (mode == 1) ? "R7 pll disabled" : "R8 pll kept", pll_en, ep);
    @(negedge clk);
    chk(brk_pulse == 0, "R3 one-cycle pulse", brk_pulse, 0);
    repeat (30) @(negedge clk);
    chk(brk_cnt == b0 + 1, "R3 single event", brk_cnt - b0, 1);
    chk(nmi_req == 1, "R5 nmi held", nmi_req, 1);
    clr_pend = 1; @(negedge clk); clr_pend = 0;
    chk(nmi_req == 0, "R5 nmi cleared", nmi_req, 1'b0);
    clr_pend = 1; @(negedge clk); clr_pend = 0;
    chk(nmi_req == 0 && sys_sel == 2'(es) && osc_en == 0 && pll_en == 1'(ep) && brk_pulse == 0,
        "R9 idle clear no effect", {nmi_req, sys_sel, osc_en, pll_en}, {1'b0, 2'(es), 1'b0, 1'(ep)});
    osc_ready = 0;
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(osc_en == 0 && pll_en == 0 && sys_sel == 0 && brk_pulse == 0 && nmi_req == 0,
        "R1 reset state", {osc_en, pll_en, sys_sel, brk_pulse, nmi_req}, 0);
    rst_n = 1;
    for (int lim = 7; lim <= 14; lim++)
      for (int mode = 0; mode < 4; mode++)
        run_case(lim, mode, 1'((lim + mode) % 2));

    @(negedge clk);
    mon_run = 0; sup_en = 0; miss_limit = 8'd9; backup_b = 1;
    sel_wr = 1; sel_wdata = 2'd2; osc_on = 1; osc_ready = 1;
    @(negedge clk); strobe_clear();
    n = brk_cnt;
    repeat (40) @(negedge clk);
    chk(brk_cnt == n && osc_en == 1, "R2 idle while supervision off", brk_cnt - n, 0);
    sup_en = 1;
    wait_brk(n);
    chk(brk_pulse && n == 9, "R2 exact arming delay", n, 9);
    osc_ready = 0; osc_on = 1;
    @(negedge clk); strobe_clear();
    n = brk_cnt;
    repeat (40) @(negedge clk);
    chk(brk_cnt == n && osc_en == 1, "R10 no rearm before ready", brk_cnt - n, 0);
    osc_ready = 1;
    wait_brk(n);
    chk(brk_pulse && n == 9 && osc_en == 0, "R10 rearm after ready", n, 9);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule